// File: doc/BRIEF.md
# Multiplexed-Address DRAM Access Controller with Refresh

This block turns single-cycle requests from a host into strobe sequences for an asynchronous-style dynamic memory. It takes a full word address and splits it into a row part and a column part. Both parts go out over one shared set of device address pins, one after the other. The row is strobed first with an active-low row strobe, then the column with an active-low column strobe. Each access is steered by active-low write-enable and output-enable lines. Write data leaves on a separate data bus with its own drive enable. Read data comes back on a separate input bus, and the block captures it at the end of the access.

A free-running interval counter raises a refresh demand every `REF_INTERVAL` clocks. When the sequencer is idle, it runs a row-strobe-only cycle with the value of an internal refresh row counter on the address pins. The counter then steps to the next row and wraps after `NUM_ROWS` rows. A pending refresh wins over a waiting host request but never cuts into an access already under way. The host sees refresh only as a busy status and a refresh-active flag. It may present a request only when busy is low, and it gets a one-clock done pulse when the access ends.

Top module: `dram_ctrl`

## Requirements
- R1: The row part is `host_addr[ROW_W+COL_W-1:COL_W]` and the column part is `host_addr[COL_W-1:0]`. Both are driven, zero-extended to `PIN_W = max(ROW_W, COL_W)`, on the same `dram_addr` pins.
- R2: In the first cycle after the accepting edge, `dram_addr` carries the row and `dram_ras_n` is still high. In the second cycle `dram_ras_n` is low and the row is held. `dram_cas_n` is low only while `dram_ras_n` is low, and while it is low `dram_addr` carries the column.
- R3: A read (`host_we`=0) drives `dram_oe_n` low and keeps `dram_we_n` high in exactly the two cycles where `dram_cas_n` is low. `dram_dq_oe` stays low. `host_rdata` takes the device data present in the last of those cycles.
- R4: A write (`host_we`=1) holds `dram_dq_oe` high with `dram_dq_out` equal to the accepted write data from the first access cycle through the precharge cycle. `dram_we_n` is low exactly while `dram_cas_n` is low, and `dram_oe_n` stays high.
- R5: `host_done` is high for exactly one clock: the fifth cycle after the accepting edge. In that cycle all strobes are high, and for a read `host_rdata` already holds the new data.
- R6: A request is taken only at an edge where `host_busy` is low. `host_busy` stays high from the accepting edge through the done cycle. A request, address, write flag or data presented while busy has no effect on memory contents.
- R7: Each refresh is a cycle in which `dram_ras_n` falls with the refresh row on `dram_addr` while `dram_cas_n` stays high. The refresh row is 0 after reset, rises by one per refresh and wraps from `NUM_ROWS-1` to 0.
- R8: A pending refresh is served before a waiting host request and never starts inside an access. Even under back-to-back requests, successive refresh row-strobe falls are `REF_INTERVAL`±8 clocks apart.
- R9: While `refresh_active` is high, `host_busy` is high and `dram_cas_n` is high.
- R10: During and right after reset, all four strobes are high and `dram_dq_oe`, `host_done` and `host_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, taken when busy is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ROW_W+COL_W | Full word address |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Captured read data |
| host_done | output | 1 | One-clock access completion pulse |
| host_busy | output | 1 | Access or refresh in progress or pending |
| refresh_active | output | 1 | Refresh cycle in progress |
| dram_addr | output | PIN_W | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | DATA_W | Data toward the device |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from the device |

## Verification
Every address of a small 16x16x8 configuration is first written with a value computed from the address and then read back. This separates a wrong or swapped row/column split from correct strobe ordering, because any mix-up aliases two locations. One write is made while a second request with different address and data is held on the port. The later readback shows whether anything taken while busy reached the memory. A long stretch of requests held high keeps the port saturated, so the measured refresh spacing shows whether refresh still takes priority. The refresh row sequence, checked against a row count that is not a power of two, exposes a wrong wrap point.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RAS,
    ST_CAS,
    ST_DATA,
    ST_PRE,
    ST_RF_SETUP,
    ST_RF_RAS,
    ST_RF_HOLD,
    ST_RF_PRE
  } seq_state_e;

  typedef enum logic [1:0] {
    SEL_ROW,
    SEL_COL,
    SEL_REF
  } addr_sel_e;

endpackage

// File: rtl/dram_ctrl_ref_timer.sv
module dram_ctrl_ref_timer #(
  parameter int unsigned REF_INTERVAL = 64,
  parameter int unsigned NUM_ROWS     = 16,
  parameter int unsigned ROW_W        = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_done,
  output logic             ref_tick,
  output logic [ROW_W-1:0] ref_row
);

  localparam int unsigned       CNT_W    = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(REF_INTERVAL - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST = ROW_W'(NUM_ROWS - 1);
  localparam logic [ROW_W:0]    ROW_LIM  = (ROW_W+1)'(NUM_ROWS);

  logic [CNT_W-1:0] cnt_q;

  // interval counter: one tick per REF_INTERVAL clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      ref_tick <= 1'b0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q    <= '0;
      ref_tick <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      ref_tick <= 1'b0;
    end
  end

  // refresh row counter, wraps at NUM_ROWS
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_row <= '0;
    end else if (ref_done) begin
      ref_row <= (ref_row == ROW_LAST) ? '0 : ref_row + 1'b1;
    end
  end

  p_row_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    {1'b0, ref_row} < ROW_LIM);

  p_tick_single_r7: assert property (@(posedge clk) disable iff (rst)
    ref_tick |=> !ref_tick);

endmodule

// File: rtl/dram_ctrl_addr_mux.sv
module dram_ctrl_addr_mux
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned ROW_W = 4,
  parameter int unsigned COL_W = 4,
  parameter int unsigned PIN_W = 4
) (
  input  addr_sel_e        sel,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] ref_row,
  output logic [PIN_W-1:0] pins
);

  always_comb begin
    case (sel)
      SEL_ROW: pins = PIN_W'(row);
      SEL_COL: pins = PIN_W'(col);
      SEL_REF: pins = PIN_W'(ref_row);
      default: pins = '0;
    endcase
  end

endmodule

// File: rtl/dram_ctrl_seq.sv
module dram_ctrl_seq
  import dram_ctrl_pkg::*;
#(
  parameter int unsigned ROW_W  = 4,
  parameter int unsigned COL_W  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PIN_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_req,
  input  logic                   host_we,
  input  logic [ROW_W+COL_W-1:0] host_addr,
  input  logic [DATA_W-1:0]      host_wdata,
  output logic [DATA_W-1:0]      host_rdata,
  output logic                   host_done,
  output logic                   host_busy,
  output logic                   refresh_active,
  input  logic                   ref_tick,
  input  logic [ROW_W-1:0]       ref_row,
  output logic                   ref_done,
  output logic [PIN_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);

  localparam int unsigned ADDR_W = ROW_W + COL_W;

  seq_state_e        state_q, state_d;
  logic              pend_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic              accept, start_ref, we_sel;
  logic [ROW_W-1:0]  row_sel;
  logic [COL_W-1:0]  col_sel;
  addr_sel_e         asel;
  logic [PIN_W-1:0]  pins_d;
  logic              in_access_d, in_strobe_d, in_ras_d, in_ref_d;

  // next-state logic: refresh before host, never inside an access
  always_comb begin
    state_d   = state_q;
    accept    = 1'b0;
    start_ref = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (pend_q) begin
          state_d   = ST_RF_SETUP;
          start_ref = 1'b1;
        end else if (host_req) begin
          state_d = ST_SETUP;
          accept  = 1'b1;
        end
      end
      ST_SETUP:    state_d = ST_RAS;
      ST_RAS:      state_d = ST_CAS;
      ST_CAS:      state_d = ST_DATA;
      ST_DATA:     state_d = ST_PRE;
      ST_PRE:      state_d = ST_IDLE;
      ST_RF_SETUP: state_d = ST_RF_RAS;
      ST_RF_RAS:   state_d = ST_RF_HOLD;
      ST_RF_HOLD:  state_d = ST_RF_PRE;
      ST_RF_PRE:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign we_sel  = accept ? host_we : we_q;
  assign row_sel = accept ? host_addr[ADDR_W-1:COL_W] : row_q;
  assign col_sel = accept ? host_addr[COL_W-1:0] : col_q;

  assign in_access_d = state_d inside {ST_SETUP, ST_RAS, ST_CAS, ST_DATA, ST_PRE};
  assign in_strobe_d = state_d inside {ST_CAS, ST_DATA};
  assign in_ras_d    = state_d inside {ST_RAS, ST_CAS, ST_DATA, ST_RF_RAS, ST_RF_HOLD};
  assign in_ref_d    = state_d inside {ST_RF_SETUP, ST_RF_RAS, ST_RF_HOLD, ST_RF_PRE};

  always_comb begin
    if (in_ref_d)                                      asel = SEL_REF;
    else if (state_d inside {ST_CAS, ST_DATA, ST_PRE}) asel = SEL_COL;
    else                                               asel = SEL_ROW;
  end

  dram_ctrl_addr_mux #(
    .ROW_W(ROW_W),
    .COL_W(COL_W),
    .PIN_W(PIN_W)
  ) addr_mux_i (
    .sel    (asel),
    .row    (row_sel),
    .col    (col_sel),
    .ref_row(ref_row),
    .pins   (pins_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      pend_q         <= 1'b0;
      row_q          <= '0;
      col_q          <= '0;
      we_q           <= 1'b0;
      dram_dq_out    <= '0;
      dram_addr      <= '0;
      dram_ras_n     <= 1'b1;
      dram_cas_n     <= 1'b1;
      dram_we_n      <= 1'b1;
      dram_oe_n      <= 1'b1;
      dram_dq_oe     <= 1'b0;
      host_done      <= 1'b0;
      host_rdata     <= '0;
      refresh_active <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= (pend_q && !start_ref) || ref_tick;
      if (accept) begin
        row_q       <= row_sel;
        col_q       <= col_sel;
        we_q        <= host_we;
        dram_dq_out <= host_wdata;
      end
      dram_addr      <= pins_d;
      dram_ras_n     <= !in_ras_d;
      dram_cas_n     <= !in_strobe_d;
      dram_we_n      <= !(in_strobe_d && we_sel);
      dram_oe_n      <= !(in_strobe_d && !we_sel);
      dram_dq_oe     <= in_access_d && we_sel;
      host_done      <= (state_d == ST_PRE);
      refresh_active <= in_ref_d;
      if (state_q == ST_DATA && !we_q) begin
        host_rdata <= dram_dq_in;
      end
    end
  end

  assign host_busy = (state_q != ST_IDLE) || pend_q;
  assign ref_done  = (state_q == ST_RF_PRE);

  p_cas_needs_ras_r2: assert property (@(posedge clk) disable iff (rst)
    !dram_cas_n |-> !dram_ras_n);

  p_row_setup_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> $stable(dram_addr));

  p_col_stable_r1: assert property (@(posedge clk) disable iff (rst)
    (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

  p_oe_we_excl_r3: assert property (@(posedge clk) disable iff (rst)
    dram_oe_n || dram_we_n);

  p_write_driven_r4: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> dram_dq_oe);

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

  p_busy_in_done_r6: assert property (@(posedge clk) disable iff (rst)
    host_done |-> host_busy);

  p_ref_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    refresh_active |-> (dram_cas_n && host_busy));

endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int unsigned ROW_W        = 4,
  parameter int unsigned COL_W        = 4,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned NUM_ROWS     = 16,
  parameter int unsigned REF_INTERVAL = 64,
  localparam int unsigned ADDR_W      = ROW_W + COL_W,
  localparam int unsigned PIN_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic              host_busy,
  output logic              refresh_active,
  output logic [PIN_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);

  logic             ref_tick;
  logic             ref_done;
  logic [ROW_W-1:0] ref_row;

  dram_ctrl_ref_timer #(
    .REF_INTERVAL(REF_INTERVAL),
    .NUM_ROWS    (NUM_ROWS),
    .ROW_W       (ROW_W)
  ) ref_timer_i (
    .clk     (clk),
    .rst     (rst),
    .ref_done(ref_done),
    .ref_tick(ref_tick),
    .ref_row (ref_row)
  );

  dram_ctrl_seq #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .DATA_W(DATA_W),
    .PIN_W (PIN_W)
  ) seq_i (
    .clk           (clk),
    .rst           (rst),
    .host_req      (host_req),
    .host_we       (host_we),
    .host_addr     (host_addr),
    .host_wdata    (host_wdata),
    .host_rdata    (host_rdata),
    .host_done     (host_done),
    .host_busy     (host_busy),
    .refresh_active(refresh_active),
    .ref_tick      (ref_tick),
    .ref_row       (ref_row),
    .ref_done      (ref_done),
    .dram_addr     (dram_addr),
    .dram_ras_n    (dram_ras_n),
    .dram_cas_n    (dram_cas_n),
    .dram_we_n     (dram_we_n),
    .dram_oe_n     (dram_oe_n),
    .dram_dq_out   (dram_dq_out),
    .dram_dq_oe    (dram_dq_oe),
    .dram_dq_in    (dram_dq_in)
  );

endmodule

// File: tb/dram_ctrl_tb_top.sv
module dram_ctrl_tb_top;

  localparam int ROW_W = 4;
  localparam int COL_W = 4;
  localparam int DATA_W = 8;
  localparam int NUM_ROWS = 12;
  localparam int REF_INTERVAL = 48;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PIN_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_req = 1'b0;
  logic              host_we = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic [DATA_W-1:0] host_rdata;
  logic              host_done, host_busy, refresh_active;
  logic [PIN_W-1:0]  dram_addr;
  logic              dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [DATA_W-1:0] dram_dq_out;
  logic              dram_dq_oe;
  logic [DATA_W-1:0] dram_dq_in;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dram_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .NUM_ROWS(NUM_ROWS), .REF_INTERVAL(REF_INTERVAL)
  ) dut_i (
    .clk(clk), .rst(rst),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_done(host_done),
    .host_busy(host_busy), .refresh_active(refresh_active),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  // behavioural device model, evaluated at falling edges
  logic [7:0]       mem [256];
  logic [ROW_W-1:0] row_lat = '0;
  logic             ras_prev = 1'b1;
  bit               cas_seen = 1'b0;
  int               cyc = 0;
  int               fall_cyc = 0;
  int               last_ref_fall = 0;
  int               ref_events = 0;
  int               exp_ref = 0;
  int               done_count = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  assign dram_dq_in = (!dram_cas_n && !dram_oe_n) ? mem[{row_lat, dram_addr}] : '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (host_done) done_count++;
      if (refresh_active)
        chk(host_busy && dram_cas_n, "R9", {host_busy, dram_cas_n}, 3);
      if (!dram_ras_n && ras_prev) begin
        row_lat  <= dram_addr;
        cas_seen = 1'b0;
        fall_cyc = cyc;
      end
      if (!dram_cas_n) begin
        cas_seen = 1'b1;
        chk(!refresh_active, "R8", refresh_active, 0);
      end
      if (!dram_cas_n && !dram_we_n) begin
        chk(dram_dq_oe, "R4", dram_dq_oe, 1);
        mem[{row_lat, dram_addr}] <= dram_dq_out;
      end
      if (dram_ras_n && !ras_prev && !cas_seen) begin
        chk(int'(row_lat) == exp_ref, "R7", row_lat, exp_ref);
        exp_ref = (exp_ref + 1) % NUM_ROWS;
        if (ref_events > 0)
          chk((fall_cyc - last_ref_fall) >= REF_INTERVAL - 8 &&
              (fall_cyc - last_ref_fall) <= REF_INTERVAL + 8,
              "R8", fall_cyc - last_ref_fall, REF_INTERVAL);
        last_ref_fall = fall_cyc;
        ref_events++;
      end
    end
    ras_prev = dram_ras_n;
  end

  // one host access with per-cycle checks; entered and left at a falling edge
  task automatic access(input bit we, input logic [7:0] a, input logic [7:0] wd,
                        input bit spam, input logic [7:0] exp_rd);
    while (host_busy) @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
    @(negedge clk);
    if (spam) begin
      host_we = 1'b1; host_addr = 8'h09; host_wdata = 8'hA5;
    end else host_req = 1'b0;
    chk(dram_ras_n && host_busy, "R2", {dram_ras_n, host_busy}, 3);
    chk(dram_addr == a[7:4], "R1", dram_addr, a[7:4]);
    chk(!refresh_active, "R8", refresh_active, 0);
    @(negedge clk);
    chk(!dram_ras_n && dram_cas_n && dram_addr == a[7:4], "R2", dram_addr, a[7:4]);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (k == 1) host_req = 1'b0;
      chk(!dram_cas_n && !dram_ras_n, "R2", {dram_ras_n, dram_cas_n}, 0);
      chk(dram_addr == a[3:0], "R1", dram_addr, a[3:0]);
      if (we) begin
        chk(!dram_we_n && dram_oe_n && dram_dq_oe, "R4", {dram_we_n, dram_oe_n, dram_dq_oe}, 3);
        chk(dram_dq_out == wd, "R4", dram_dq_out, wd);
      end else begin
        chk(dram_we_n && !dram_oe_n && !dram_dq_oe, "R3", {dram_we_n, dram_oe_n, dram_dq_oe}, 4);
      end
      chk(!host_done && host_busy, "R6", {host_done, host_busy}, 1);
    end
    @(negedge clk);
    chk(host_done, "R5", host_done, 1);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R5",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    chk(host_busy, "R6", host_busy, 1);
    if (we) chk(dram_dq_oe && dram_dq_out == wd, "R4", dram_dq_out, wd);
    else    chk(host_rdata == exp_rd, "R3", host_rdata, exp_rd);
    @(negedge clk);
    chk(!host_done, "R5", host_done, 0);
  endtask

  initial begin
    int d0, r0;
    repeat (5) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R10",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    chk(!dram_dq_oe && !host_done && !host_busy, "R10",
        {dram_dq_oe, host_done, host_busy}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!host_busy && dram_ras_n, "R10", {host_busy, dram_ras_n}, 1);

    // exhaustive write then read over all addresses
    for (int a = 0; a < 256; a++) access(1'b1, 8'(a), pat(a), 1'b0, 8'h00);
    for (int a = 0; a < 256; a++) access(1'b0, 8'(a), 8'h00, 1'b0, pat(a));

    // request held while busy must not reach memory
    access(1'b1, 8'h05, 8'h5A, 1'b1, 8'h00);
    access(1'b0, 8'h09, 8'h00, 1'b0, pat(9));
    access(1'b0, 8'h05, 8'h00, 1'b0, 8'h5A);

    // saturated request port: refresh still served on schedule
    d0 = done_count; r0 = ref_events;
    host_req = 1'b1; host_we = 1'b0; host_addr = 8'h3C;
    repeat (400) @(negedge clk);
    host_req = 1'b0;
    repeat (12) @(negedge clk);
    chk(ref_events - r0 >= 7, "R8", ref_events - r0, 7);
    chk(done_count - d0 >= 40, "R6", done_count - d0, 40);
    chk(ref_events > 2 * NUM_ROWS, "R7", ref_events, 2 * NUM_ROWS);
    access(1'b0, 8'h3C, 8'h00, 1'b0, pat(8'h3C));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule